// File: doc/BRIEF.md
# Little-Endian Split Access Unit

This unit sits between a processor load/store port and a memory bus that is 32 bits wide and addressed by byte. It takes one request at a time. Each request carries a byte address, an operand size of one, two or four bytes, a direction and, for stores, the operand. The unit places the operand's bytes on the bus lanes in little-endian order, so the least significant byte sits at the lowest address. It also drives a byte-enable mask that marks the lanes the access uses.

An operand that fits inside one 4-byte bus word takes one bus cycle, even when its address does not match its size. An operand that spills into the next bus word is never refused. The unit issues the lower bus word first and then the following one, and joins the two halves of a load before it answers. That second bus cycle is the price of such an access. Every response carries a flag for an address that does not match the operand size and a second flag for an access that needed two bus cycles.

The request side uses a valid/ready handshake and is ready only when the unit is idle. The response is a strobe one cycle long that comes with the load data or the store completion.

Top module: `split_access_unit`

## Requirements
- R1: While reset is asserted and right after it, req_ready is 1 and bus_valid and rsp_valid are 0.
- R2: req_size encodes 0 = one byte, 1 = two bytes, 2 = four bytes. A load returns in rsp_rdata bits [8k+7:8k] the byte at address req_addr+k, for k below the size. Bits above the operand are 0.
- R3: req_ready is 1 only while the unit is idle. It is 0 from the cycle after a request is accepted through the cycle of its response, and 1 again in the cycle after that.
- R4: An access whose bytes all lie in one aligned 4-byte word makes exactly one bus cycle. That cycle has bus_addr = req_addr with bits [1:0] cleared, and bus_be bit i is set exactly when a byte of the operand has address bits [1:0] equal to i.
- R5: An access that crosses into the next 4-byte word makes exactly two bus cycles. The first goes to the lower word and the second to that word's address plus 4, each with the byte enables of the bytes it holds.
- R6: In a store bus cycle, lane i of bus_wdata (bits [8i+7:8i]) carries the operand byte whose address falls in that lane. Lanes whose enable is 0 carry 0. bus_write is 1 for stores and 0 for loads.
- R7: rsp_valid is high for exactly one cycle, the cycle after the handshake (bus_valid and bus_ready both high) of the access's last bus cycle.
- R8: rsp_misaligned is 1 when a two-byte access has an odd address or a four-byte access has an address that is not a multiple of 4, and 0 otherwise. rsp_split is 1 exactly when the access took two bus cycles.
- R9: While bus_valid is 1 and bus_ready is 0, bus_addr, bus_be, bus_write and bus_wdata hold their values.
- R10: The response to a store has rsp_rdata equal to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit idle, request taken this cycle |
| req_write | input | 1 | 1 = store, 0 = load |
| req_size | input | 2 | 0 one byte, 1 two bytes, 2 four bytes |
| req_addr | input | ADDR_W | Byte address of the operand |
| req_wdata | input | 32 | Store operand, least significant byte first in memory |
| bus_valid | output | 1 | Bus cycle requested |
| bus_ready | input | 1 | Memory takes the bus cycle |
| bus_write | output | 1 | Bus cycle is a store |
| bus_addr | output | ADDR_W | Word-aligned bus address |
| bus_be | output | 4 | Byte lane enables |
| bus_wdata | output | 32 | Lane-steered store data |
| bus_rdata | input | 32 | Load data, valid during the handshake cycle |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_rdata | output | 32 | Assembled load data, zero for stores |
| rsp_misaligned | output | 1 | Address does not match operand size |
| rsp_split | output | 1 | Access used two bus cycles |

## Verification
The assertions take for granted that req_size is never 3 and that the memory presents load data in the same cycle it raises bus_ready. They do not depend on the request fields staying stable, because a request is taken in the first cycle it is offered to an idle unit. The stimulus only issues sizes 0 to 2 and uses a memory model that answers from its array in the handshake cycle. It stalls bus_ready at random so that the hold and two-cycle orderings are exercised under back-pressure.

// File: rtl/split_pkg.sv
package split_pkg;

  typedef enum logic [1:0] {
    SZ_ONE  = 2'd0,
    SZ_TWO  = 2'd1,
    SZ_FOUR = 2'd2
  } acc_size_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOW  = 2'd1,
    ST_HIGH = 2'd2,
    ST_DONE = 2'd3
  } seq_state_e;

endpackage

// File: rtl/split_lane_plan.sv
module split_lane_plan #(
  parameter int LANES  = 4,
  parameter int BYTE_W = 8
) (
  input  logic [$clog2(LANES)-1:0] off,
  input  logic [1:0]               size,
  input  logic [LANES*BYTE_W-1:0]  wdata,
  output logic [$clog2(LANES):0]   nbytes,
  output logic [LANES-1:0]         be_lo,
  output logic [LANES-1:0]         be_hi,
  output logic [LANES*BYTE_W-1:0]  wd_lo,
  output logic [LANES*BYTE_W-1:0]  wd_hi,
  output logic                     crosses,
  output logic                     misaligned
);
  import split_pkg::*;

  localparam int OFF_W  = $clog2(LANES);
  localparam int DATA_W = LANES * BYTE_W;
  localparam int WIDE   = 2 * LANES;
  localparam int CW     = OFF_W + 2;
  localparam int SH_B   = $clog2(BYTE_W);

  logic [WIDE-1:0]     span;
  logic [2*DATA_W-1:0] shifted;
  logic [2*DATA_W-1:0] steered;
  logic [OFF_W:0]      nb_m1;

  always_comb begin
    case (acc_size_e'(size))
      SZ_ONE:  nbytes = (OFF_W+1)'(1);
      SZ_TWO:  nbytes = (OFF_W+1)'(2);
      default: nbytes = (OFF_W+1)'(LANES);
    endcase
  end

  assign shifted = {{DATA_W{1'b0}}, wdata} << {off, {SH_B{1'b0}}};

  for (genvar i = 0; i < WIDE; i++) begin : g_byte
    assign span[i] = (CW'(i) >= CW'(off)) && (CW'(i) < CW'(off) + CW'(nbytes));
    assign steered[i*BYTE_W +: BYTE_W] = span[i] ? shifted[i*BYTE_W +: BYTE_W] : '0;
  end

  assign be_lo   = span[LANES-1:0];
  assign be_hi   = span[WIDE-1:LANES];
  assign wd_lo   = steered[DATA_W-1:0];
  assign wd_hi   = steered[2*DATA_W-1:DATA_W];
  assign crosses = |be_hi;

  assign nb_m1      = nbytes - 1'b1;
  assign misaligned = |(off & nb_m1[OFF_W-1:0]);

endmodule

// File: rtl/split_seq.sv
module split_seq (
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid,
  input  logic crosses,
  input  logic bus_ready,
  output logic req_ready,
  output logic load,
  output logic bus_valid,
  output logic beat_hi,
  output logic cap_lo,
  output logic cap_hi,
  output logic rsp_valid
);
  import split_pkg::*;

  seq_state_e state_q, state_d;

  always_comb begin
    state_d   = state_q;
    req_ready = 1'b0;
    load      = 1'b0;
    bus_valid = 1'b0;
    beat_hi   = 1'b0;
    cap_lo    = 1'b0;
    cap_hi    = 1'b0;
    rsp_valid = 1'b0;
    case (state_q)
      ST_IDLE: begin
        req_ready = 1'b1;
        if (req_valid) begin
          load    = 1'b1;
          state_d = ST_LOW;
        end
      end
      ST_LOW: begin
        bus_valid = 1'b1;
        if (bus_ready) begin
          cap_lo  = 1'b1;
          state_d = crosses ? ST_HIGH : ST_DONE;
        end
      end
      ST_HIGH: begin
        bus_valid = 1'b1;
        beat_hi   = 1'b1;
        if (bus_ready) begin
          cap_hi  = 1'b1;
          state_d = ST_DONE;
        end
      end
      default: begin
        rsp_valid = 1'b1;
        state_d   = ST_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

endmodule

// File: rtl/split_merge.sv
module split_merge #(
  parameter int LANES  = 4,
  parameter int BYTE_W = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cap_lo,
  input  logic                     cap_hi,
  input  logic [LANES*BYTE_W-1:0]  bus_rdata,
  input  logic [$clog2(LANES)-1:0] off,
  input  logic [$clog2(LANES):0]   nbytes,
  input  logic                     is_write,
  output logic [LANES*BYTE_W-1:0]  rdata
);
  localparam int OFF_W  = $clog2(LANES);
  localparam int DATA_W = LANES * BYTE_W;
  localparam int SH_B   = $clog2(BYTE_W);

  logic [2*DATA_W-1:0] pair_q;
  logic [2*DATA_W-1:0] aligned;
  logic [DATA_W-1:0]   kept;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pair_q <= '0;
    end else begin
      if (cap_lo) pair_q[DATA_W-1:0]        <= bus_rdata;
      if (cap_hi) pair_q[2*DATA_W-1:DATA_W] <= bus_rdata;
    end
  end

  assign aligned = pair_q >> {off, {SH_B{1'b0}}};

  for (genvar i = 0; i < LANES; i++) begin : g_keep
    assign kept[i*BYTE_W +: BYTE_W] =
      ((OFF_W+1)'(i) < nbytes) ? aligned[i*BYTE_W +: BYTE_W] : '0;
  end

  assign rdata = is_write ? '0 : kept;

endmodule

// File: rtl/split_access_unit.sv
module split_access_unit #(
  parameter  int ADDR_W = 32,
  parameter  int LANES  = 4,
  parameter  int BYTE_W = 8,
  localparam int DATA_W = LANES * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [1:0]        req_size,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              bus_valid,
  input  logic              bus_ready,
  output logic              bus_write,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [LANES-1:0]  bus_be,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic [DATA_W-1:0] bus_rdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              rsp_misaligned,
  output logic              rsp_split
);
  localparam int OFF_W = $clog2(LANES);

  logic              load, beat_hi, cap_lo, cap_hi, crosses;
  logic              q_write;
  logic [1:0]        q_size;
  logic [ADDR_W-1:0] q_addr;
  logic [DATA_W-1:0] q_wdata;
  logic [OFF_W:0]    nbytes;
  logic [LANES-1:0]  be_lo, be_hi;
  logic [DATA_W-1:0] wd_lo, wd_hi;
  logic [ADDR_W-1:0] base_addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_write <= 1'b0;
      q_size  <= '0;
      q_addr  <= '0;
      q_wdata <= '0;
    end else if (load) begin
      q_write <= req_write;
      q_size  <= req_size;
      q_addr  <= req_addr;
      q_wdata <= req_wdata;
    end
  end

  split_lane_plan #(.LANES(LANES), .BYTE_W(BYTE_W)) u_plan (
    .off        (q_addr[OFF_W-1:0]),
    .size       (q_size),
    .wdata      (q_wdata),
    .nbytes     (nbytes),
    .be_lo      (be_lo),
    .be_hi      (be_hi),
    .wd_lo      (wd_lo),
    .wd_hi      (wd_hi),
    .crosses    (crosses),
    .misaligned (rsp_misaligned)
  );

  split_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .crosses   (crosses),
    .bus_ready (bus_ready),
    .req_ready (req_ready),
    .load      (load),
    .bus_valid (bus_valid),
    .beat_hi   (beat_hi),
    .cap_lo    (cap_lo),
    .cap_hi    (cap_hi),
    .rsp_valid (rsp_valid)
  );

  split_merge #(.LANES(LANES), .BYTE_W(BYTE_W)) u_merge (
    .clk       (clk),
    .rst_n     (rst_n),
    .cap_lo    (cap_lo),
    .cap_hi    (cap_hi),
    .bus_rdata (bus_rdata),
    .off       (q_addr[OFF_W-1:0]),
    .nbytes    (nbytes),
    .is_write  (q_write),
    .rdata     (rsp_rdata)
  );

  assign base_addr = {q_addr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
  assign bus_addr  = beat_hi ? base_addr + ADDR_W'(LANES) : base_addr;
  assign bus_be    = beat_hi ? be_hi : be_lo;
  assign bus_wdata = beat_hi ? wd_hi : wd_lo;
  assign bus_write = q_write;
  assign rsp_split = crosses;

endmodule

// File: rtl/split_access_checker.sv
module split_access_checker #(
  parameter  int ADDR_W = 32,
  parameter  int LANES  = 4,
  parameter  int BYTE_W = 8,
  localparam int DATA_W = LANES * BYTE_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              bus_valid,
  input logic              bus_ready,
  input logic              bus_write,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [LANES-1:0]  bus_be,
  input logic [DATA_W-1:0] bus_wdata,
  input logic              rsp_valid,
  input logic              rsp_misaligned,
  input logic              rsp_split
);

  // R3: after a request is taken the unit stops accepting
  a_r3_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  // R4: every bus cycle enables at least one lane
  a_r4_be_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid |-> (bus_be != '0));

  // R5: a bus cycle directly after a handshake targets the next word
  a_r5_next_word: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_ready) |=> (!bus_valid || bus_addr == $past(bus_addr) + ADDR_W'(LANES)));

  // R7: response strobe lasts one cycle and follows a bus handshake
  a_r7_rsp_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  a_r7_rsp_after_bus: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(bus_valid && bus_ready));

  // R8: a split access always has a mismatched address
  a_r8_split_is_misaligned: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_split) |-> rsp_misaligned);

  // R9: bus cycle is held stable under back-pressure
  a_r9_bus_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_ready) |=> (bus_valid && $stable(bus_addr) && $stable(bus_be)
                                  && $stable(bus_wdata) && $stable(bus_write)));

endmodule

bind split_access_unit split_access_checker #(
  .ADDR_W(ADDR_W), .LANES(LANES), .BYTE_W(BYTE_W)
) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .req_valid      (req_valid),
  .req_ready      (req_ready),
  .bus_valid      (bus_valid),
  .bus_ready      (bus_ready),
  .bus_write      (bus_write),
  .bus_addr       (bus_addr),
  .bus_be         (bus_be),
  .bus_wdata      (bus_wdata),
  .rsp_valid      (rsp_valid),
  .rsp_misaligned (rsp_misaligned),
  .rsp_split      (rsp_split)
);

// File: tb/split_access_unit_test.sv
`timescale 1ns/1ps
module split_access_unit_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_ready, req_write;
  logic [1:0]  req_size;
  logic [31:0] req_addr, req_wdata;
  logic        bus_valid, bus_ready, bus_write;
  logic [31:0] bus_addr, bus_wdata, bus_rdata;
  logic [3:0]  bus_be;
  logic        rsp_valid, rsp_misaligned, rsp_split;
  logic [31:0] rsp_rdata;

  always #2 clk = ~clk;

  split_access_unit uut (.*);

  logic [7:0] mem [256];
  assign bus_rdata = {mem[8'(bus_addr + 32'd3)], mem[8'(bus_addr + 32'd2)],
                      mem[8'(bus_addr + 32'd1)], mem[8'(bus_addr)]};

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit run = 0;
  bit stall_bus = 0;

  // reference model state
  bit          idle_exp, bus_on, rsp_due;
  logic [31:0] q_ba[$];
  logic [3:0]  q_be[$];
  logic [31:0] q_wd[$];
  logic [31:0] exp_rdata;
  bit          exp_write, exp_mis, exp_split;

  task automatic chk(bit ok, string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s got %h exp %h", tag, got, exp);
    end
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  always @(posedge clk) begin
    #1 bus_ready <= stall_bus ? (($urandom % 3) != 0) : 1'b1;
  end

  always @(negedge clk) begin
    if (rst_n && run) begin
      bit last_hs;
      last_hs = 0;
      chk(req_ready == idle_exp, "R3 req_ready", 32'(req_ready), 32'(idle_exp));
      chk(bus_valid == bus_on, "R4/R5 bus_valid", 32'(bus_valid), 32'(bus_on));
      if (bus_on && bus_valid) begin
        chk(bus_addr == q_ba[0], "R5/R9 bus_addr", bus_addr, q_ba[0]);
        chk(bus_be == q_be[0], "R4/R9 bus_be", 32'(bus_be), 32'(q_be[0]));
        chk(bus_write == exp_write, "R6 bus_write", 32'(bus_write), 32'(exp_write));
        if (exp_write)
          chk(bus_wdata == q_wd[0], "R6 bus_wdata", bus_wdata, q_wd[0]);
      end
      chk(rsp_valid == rsp_due, "R7 rsp_valid", 32'(rsp_valid), 32'(rsp_due));
      if (rsp_due && rsp_valid) begin
        chk(rsp_rdata == exp_rdata, exp_write ? "R10 rsp_rdata" : "R2 rsp_rdata",
            rsp_rdata, exp_rdata);
        chk(rsp_misaligned == exp_mis, "R8 rsp_misaligned", 32'(rsp_misaligned), 32'(exp_mis));
        chk(rsp_split == exp_split, "R8 rsp_split", 32'(rsp_split), 32'(exp_split));
      end
      // advance the model to the next cycle
      if (bus_on && bus_ready) begin
        if (exp_write)
          for (int l = 0; l < 4; l++)
            if (q_be[0][l]) mem[8'(q_ba[0] + 32'(l))] = q_wd[0][l*8 +: 8];
        void'(q_ba.pop_front());
        void'(q_be.pop_front());
        void'(q_wd.pop_front());
        if (q_ba.size() == 0) begin
          bus_on  = 0;
          last_hs = 1;
        end
      end
      if (rsp_due) idle_exp = 1;
      rsp_due = last_hs;
      if (idle_exp && req_valid && !rsp_valid) begin
        int a, n, w0, wl;
        a  = int'(req_addr);
        n  = (req_size == 2'd0) ? 1 : (req_size == 2'd1) ? 2 : 4;
        w0 = a >> 2;
        wl = (a + n - 1) >> 2;
        for (int b = 0; b <= wl - w0; b++) begin
          logic [3:0]  be;
          logic [31:0] wd;
          be = '0;
          wd = '0;
          for (int k = 0; k < n; k++)
            if (((a + k) >> 2) == w0 + b) begin
              be[(a + k) % 4] = 1'b1;
              wd[((a + k) % 4)*8 +: 8] = req_wdata[k*8 +: 8];
            end
          q_ba.push_back(32'((w0 + b) * 4));
          q_be.push_back(be);
          q_wd.push_back(wd);
        end
        exp_write = req_write;
        exp_rdata = '0;
        if (!req_write)
          for (int k = 0; k < n; k++) exp_rdata[k*8 +: 8] = mem[8'(a + k)];
        exp_mis   = (n == 2 && (a % 2) != 0) || (n == 4 && (a % 4) != 0);
        exp_split = (wl != w0);
        bus_on    = 1;
        idle_exp  = 0;
      end
    end
  end

  // drive a request and return once it has been taken
  task automatic issue(bit wr, logic [1:0] sz, int addr, logic [31:0] wd);
    req_valid = 1'b1;
    req_write = wr;
    req_size  = sz;
    req_addr  = 32'(addr);
    req_wdata = wd;
    forever begin
      @(negedge clk);
      if (req_ready) break;
    end
    @(posedge clk);
    #1;
  endtask

  task automatic settle();
    req_valid = 1'b0;
    forever begin
      @(negedge clk);
      if (idle_exp) break;
    end
    @(posedge clk);
    #1;
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'(i * 7 + 3);
    rst_n = 1'b0;
    req_valid = 1'b0;
    req_write = 1'b0;
    req_size = '0;
    req_addr = '0;
    req_wdata = '0;
    bus_ready = 1'b1;
    idle_exp = 1;
    bus_on = 0;
    rsp_due = 0;
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state
    chk(req_ready == 1'b1, "R1 req_ready", 32'(req_ready), 32'd1);
    chk(bus_valid == 1'b0, "R1 bus_valid", 32'(bus_valid), 32'd0);
    chk(rsp_valid == 1'b0, "R1 rsp_valid", 32'(rsp_valid), 32'd0);
    rst_n = 1'b1;
    run = 1;
    @(posedge clk);
    #1;
    chk(req_ready == 1'b1 && !bus_valid, "R1 after release", 32'(req_ready), 32'd1);

    // aligned four-byte stores fill memory (R4, R6)
    for (int w = 0; w < 64; w++) issue(1'b1, 2'd2, w * 4, $urandom);
    settle();

    // loads of each size at each offset, one at a time (R2, R4, R5, R8)
    for (int s = 0; s < 3; s++)
      for (int o = 0; o < 4; o++) begin
        issue(1'b0, 2'(s), 32 + o, 32'h0);
        settle();
      end

    // stores of each size at each offset with stray upper bits, then read back (R6, R10)
    for (int s = 0; s < 3; s++)
      for (int o = 0; o < 4; o++) begin
        issue(1'b1, 2'(s), 64 + s * 16 + o * 4 + o, 32'hA5C3_9E17 + 32'(o));
        settle();
        issue(1'b0, 2'd2, 64 + s * 16 + o * 4, 32'h0);
        issue(1'b0, 2'd2, 68 + s * 16 + o * 4, 32'h0);
        settle();
      end

    // crossing at the top of the window (R5)
    issue(1'b0, 2'd2, 254, 32'h0);
    issue(1'b1, 2'd1, 255, 32'h0000_BEEF);
    settle();

    // random traffic with back-pressure, requests held back to back (R3, R7, R9)
    stall_bus = 1;
    for (int t = 0; t < 400; t++) begin
      issue(1'(($urandom % 2)), 2'($urandom % 3), int'($urandom % 256), $urandom);
      if (($urandom % 4) == 0) settle();
    end
    settle();
    stall_bus = 0;
    repeat (4) @(posedge clk);
    finish_run();
  end

endmodule